// File: doc/BRIEF.md
# Video Sync Reference Port Controller

This block keeps the horizontal and vertical timing of a digital video encoder and shares it with the outside world through two sync pins, pin A and pin B. Each pin can be an output or an input. A pixel counter runs modulo a selectable line length of 1716 or 1728 clocks. A line counter wraps at a programmable number of lines per field, and a small field counter tracks the field parity and the field sequence.

Set as an output, pin A carries a vertical reference: a pulse on the first line of every field, an odd/even frame level, or a pulse in the first line of every fourth or eighth field. Set as an output, pin B carries a horizontal reference window on each line. That window can either run through vertical blanking or be suppressed outside the active line range. Set as an input, the selected pin resynchronises the pixel counter on its active edge. The counter is loaded with a trigger phase, so a larger phase means less delay for all derived timing. When pin B is an input in blanking mode, it also drives the internal blanking flag.

Configuration is written through a narrow synchronous register port. Address 0 holds the control word. Addresses 1 to 6 hold the trigger phase, the window start and end pixels, the first and last active lines, and the number of lines per field. Address 7 has no register.

Top module: `sync_ref_port`

## Requirements
- R1: After reset both output enables are 0, both pin outputs are 0, and blankOut is 1 because line 0 lies before the default first active line 20. The trigger phase resets to 57, and the control word resets to 0.
- R2: Control bit 1 sets pin A as an output and bit 3 sets pin B as an output. Each output enable follows its direction bit on the cycle after the write. An output whose pin is an input is held at 0.
- R3: Control bit 0 is the pin A polarity and bit 2 is the pin B polarity. At 1 the output is active low, and at 0 it is active high.
- R4: An input pin resynchronises on the rising edge when its polarity bit is 0 and on the falling edge when it is 1. The pixel counter is loaded with the trigger phase at the clock edge that samples the active edge, and it counts up by one per clock from there.
- R5: Control bit 7 set gives lines of 1716 clocks and cleared gives 1728. The pixel counter wraps to 0 after the last pixel. A trigger phase above 1715 (or above 1727 for the long line) is loaded as 1715 (or 1727).
- R6: With pin B as an output and control bit 4 at 0, pin B is active while the pixel count is at least the start register (address 2) and below the end register (address 3), on every line.
- R7: With control bit 4 at 1, the pin B window is suppressed on lines below the first active line (address 4) or above the last active line (address 5).
- R8: Pin A type code 00 (control bits 9:8) gives a pulse that lasts the whole of line 0 in every field. A field has as many lines as address 6 holds, and a value of 0 is treated as 1.
- R9: Pin A type code 01 gives a frame level that is active for a whole field and inactive for the next, in alternation.
- R10: Pin A type code 10 gives a line-0 pulse once every 4 fields when control bit 6 is 0, and once every 8 fields when it is 1.
- R11: Pin A type code 11 keeps the pin at its inactive level.
- R12: Control bit 5 chooses the resync source: pin A input at 0, pin B input at 1. A pin set as an output never resynchronises.
- R13: When pin B is an input and control bit 4 is 1, blankOut is the inverse of pin B's active level. Otherwise blankOut is 1 outside the active line range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 11 | Register write data |
| pinAIn | input | 1 | Pin A input level |
| pinAOut | output | 1 | Pin A output level |
| pinAOe | output | 1 | Pin A output enable |
| pinBIn | input | 1 | Pin B input level |
| pinBOut | output | 1 | Pin B output level |
| pinBOe | output | 1 | Pin B output enable |
| blankOut | output | 1 | Internal blanking flag, 1 while blanking |

## Verification
The hardest situation to reach is the field-sequence pulse, because it needs many whole fields to pass. The bench gets there by setting one line per field, so a full 8-field sequence takes only about 14k clocks, and then measures the pulse-to-pulse distance. Phase clamping and line-length wrap are reached by loading out-of-range trigger values and sampling the horizontal window a counted number of clocks after a forced input edge. Resync from pin B is observed indirectly, through the delay to the next line-rate transition on pin A.

// File: rtl/syncref_pkg.sv
package syncref_pkg;
  localparam int PIX_W     = 11;
  localparam int LINE_W    = 10;
  localparam int FLD_W     = 3;
  localparam int ADDR_W    = 3;
  localparam int LEN_LONG  = 1728;
  localparam int LEN_SHORT = 1716;

  typedef enum logic [1:0] {
    A_VSYNC = 2'b00,
    A_FRAME = 2'b01,
    A_SEQ   = 2'b10,
    A_NONE  = 2'b11
  } aTypeT;

  // control word, bit 0 at the bottom
  typedef struct packed {
    aTypeT aType;
    logic  shortLine;
    logic  seq8;
    logic  srcB;
    logic  blankSel;
    logic  dirB;
    logic  polB;
    logic  dirA;
    logic  polA;
  } cfgT;

  // control -> datapath
  typedef struct packed {
    logic              hLoad;
    logic [PIX_W-1:0]  phase;
    logic              shortLine;
    logic [LINE_W-1:0] fieldLines;
  } strobeT;

  // datapath -> control
  typedef struct packed {
    logic [PIX_W-1:0]  pix;
    logic [LINE_W-1:0] line;
    logic [FLD_W-1:0]  field;
  } countT;
endpackage

// File: rtl/sync_counters.sv
module sync_counters
  import syncref_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  strobeT strobe,
  output countT  cnt
);
  localparam logic [PIX_W-1:0] LAST_LONG  = PIX_W'(LEN_LONG - 1);
  localparam logic [PIX_W-1:0] LAST_SHORT = PIX_W'(LEN_SHORT - 1);

  logic [PIX_W-1:0]  pixQ;
  logic [LINE_W-1:0] lineQ;
  logic [FLD_W-1:0]  fieldQ;
  logic [PIX_W-1:0]  lastPix;
  logic [LINE_W:0]   lineNext;
  logic              lineEnd;
  logic              fieldEnd;

  always_comb begin
    lastPix  = strobe.shortLine ? LAST_SHORT : LAST_LONG;
    lineEnd  = !strobe.hLoad && (pixQ >= lastPix);
    lineNext = {1'b0, lineQ} + (LINE_W+1)'(1);
    fieldEnd = lineEnd && (lineNext >= {1'b0, strobe.fieldLines});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixQ   <= '0;
      lineQ  <= '0;
      fieldQ <= '0;
    end else begin
      if (strobe.hLoad)  pixQ <= strobe.phase;
      else if (lineEnd)  pixQ <= '0;
      else               pixQ <= pixQ + PIX_W'(1);

      if (fieldEnd) begin
        lineQ  <= '0;
        fieldQ <= fieldQ + FLD_W'(1);
      end else if (lineEnd) begin
        lineQ <= lineNext[LINE_W-1:0];
      end
    end
  end

  assign cnt = {pixQ, lineQ, fieldQ};

  AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hLoad |=> pixQ == $past(strobe.phase)); // R4
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |=> pixQ == '0); // R5
  AST_FIELD_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fieldQ) |-> lineQ == '0); // R8
endmodule

// File: rtl/sync_ctrl.sv
module sync_ctrl
  import syncref_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PIX_W-1:0]  wrData,
  input  logic              pinAIn,
  input  logic              pinBIn,
  input  countT             cnt,
  output strobeT            strobe,
  output logic              pinAOut,
  output logic              pinAOe,
  output logic              pinBOut,
  output logic              pinBOe,
  output logic              blankOut
);
  localparam int CFG_W = $bits(cfgT);
  localparam logic [ADDR_W-1:0] AD_CFG   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] AD_TRIG  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] AD_HBEG  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] AD_HEND  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] AD_FIRST = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] AD_LAST  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] AD_LINES = ADDR_W'(6);
  localparam logic [PIX_W-1:0]  MAX_LONG  = PIX_W'(LEN_LONG - 1);
  localparam logic [PIX_W-1:0]  MAX_SHORT = PIX_W'(LEN_SHORT - 1);
  localparam logic [PIX_W-1:0]  TRIG_RST  = PIX_W'(57);
  localparam logic [PIX_W-1:0]  HEND_RST  = PIX_W'(128);
  localparam logic [LINE_W-1:0] FIRST_RST = LINE_W'(20);
  localparam logic [LINE_W-1:0] LAST_RST  = LINE_W'(259);
  localparam logic [LINE_W-1:0] LINES_RST = LINE_W'(262);
  localparam logic [FLD_W-1:0]  MASK4 = FLD_W'(3);
  localparam logic [FLD_W-1:0]  MASK8 = FLD_W'(7);

  cfgT               cfgQ;
  logic [PIX_W-1:0]  trigQ, hBegQ, hEndQ;
  logic [LINE_W-1:0] firstQ, lastQ, linesQ;
  logic              prevA, prevB;

  logic [PIX_W-1:0]  maxPhase, phase;
  logic              edgeA, edgeB, syncHit;
  logic [FLD_W-1:0]  seqMask;
  logic              topLine, aRaw, hRef, inRange, bRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= '0;
      trigQ  <= TRIG_RST;
      hBegQ  <= '0;
      hEndQ  <= HEND_RST;
      firstQ <= FIRST_RST;
      lastQ  <= LAST_RST;
      linesQ <= LINES_RST;
    end else if (wrEn) begin
      case (wrAddr)
        AD_CFG:   cfgQ   <= cfgT'(wrData[CFG_W-1:0]);
        AD_TRIG:  trigQ  <= wrData;
        AD_HBEG:  hBegQ  <= wrData;
        AD_HEND:  hEndQ  <= wrData;
        AD_FIRST: firstQ <= wrData[LINE_W-1:0];
        AD_LAST:  lastQ  <= wrData[LINE_W-1:0];
        AD_LINES: linesQ <= wrData[LINE_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= pinAIn;
      prevB <= pinBIn;
    end
  end

  always_comb begin
    maxPhase = cfgQ.shortLine ? MAX_SHORT : MAX_LONG;
    phase    = (trigQ > maxPhase) ? maxPhase : trigQ;
    edgeA    = cfgQ.polA ? (prevA & ~pinAIn) : (~prevA & pinAIn);
    edgeB    = cfgQ.polB ? (prevB & ~pinBIn) : (~prevB & pinBIn);
    syncHit  = cfgQ.srcB ? (edgeB & ~cfgQ.dirB) : (edgeA & ~cfgQ.dirA);
    strobe   = {syncHit, phase, cfgQ.shortLine, linesQ};

    seqMask = cfgQ.seq8 ? MASK8 : MASK4;
    topLine = (cnt.line == '0);
    case (cfgQ.aType)
      A_VSYNC: aRaw = topLine;
      A_FRAME: aRaw = ~cnt.field[0];
      A_SEQ:   aRaw = topLine && ((cnt.field & seqMask) == '0);
      default: aRaw = 1'b0;
    endcase

    hRef    = (cnt.pix >= hBegQ) && (cnt.pix < hEndQ);
    inRange = (cnt.line >= firstQ) && (cnt.line <= lastQ);
    bRaw    = hRef && (!cfgQ.blankSel || inRange);

    pinAOe   = cfgQ.dirA;
    pinAOut  = cfgQ.dirA & (aRaw ^ cfgQ.polA);
    pinBOe   = cfgQ.dirB;
    pinBOut  = cfgQ.dirB & (bRaw ^ cfgQ.polB);
    blankOut = (!cfgQ.dirB && cfgQ.blankSel) ? ~(pinBIn ^ cfgQ.polB) : ~inRange;
  end

  AST_DIR_A_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == AD_CFG) |=> pinAOe == $past(wrData[1])); // R2
  AST_B_QUIET_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    !pinBOe |-> !pinBOut); // R2
  AST_SEQ_TOP_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (pinAOe && cfgQ.aType == A_SEQ && (pinAOut != cfgQ.polA)) |-> cnt.line == '0); // R10
  AST_HREF_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (pinBOe && (pinBOut != cfgQ.polB)) |-> (cnt.pix >= hBegQ && cnt.pix < hEndQ)); // R6
  AST_SRC_GATED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hLoad |-> (cfgQ.srcB ? !cfgQ.dirB : !cfgQ.dirA)); // R12
endmodule

// File: rtl/sync_ref_port.sv
module sync_ref_port
  import syncref_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PIX_W-1:0]  wrData,
  input  logic              pinAIn,
  output logic              pinAOut,
  output logic              pinAOe,
  input  logic              pinBIn,
  output logic              pinBOut,
  output logic              pinBOe,
  output logic              blankOut
);
  strobeT strobe;
  countT  cnt;

  sync_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinAIn(pinAIn), .pinBIn(pinBIn), .cnt(cnt), .strobe(strobe),
    .pinAOut(pinAOut), .pinAOe(pinAOe), .pinBOut(pinBOut), .pinBOe(pinBOe),
    .blankOut(blankOut)
  );

  sync_counters uCount (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cnt(cnt)
  );
endmodule

// File: tb/sync_ref_port_test.sv
`timescale 1ns/1ps
module sync_ref_port_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [10:0] wrData = '0;
  logic        pinAIn = 1'b0;
  logic        pinBIn = 1'b0;
  logic        pinAOut, pinAOe, pinBOut, pinBOe, blankOut;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sync_ref_port uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinAIn(pinAIn), .pinAOut(pinAOut), .pinAOe(pinAOe),
    .pinBIn(pinBIn), .pinBOut(pinBOut), .pinBOe(pinBOe), .blankOut(blankOut)
  );

  typedef struct packed {
    logic        polA;
    logic        shortL;
    logic [10:0] trig;
    logic [10:0] hBeg;
    logic [10:0] hEnd;
    logic        polB;
    logic [7:0]  delay;
  } vecT;

  localparam vecT VECS [6] = '{
    '{1'b0, 1'b1, 11'd57,   11'd60,   11'd70,   1'b0, 8'd5},
    '{1'b0, 1'b1, 11'd57,   11'd60,   11'd70,   1'b0, 8'd20},
    '{1'b1, 1'b0, 11'd100,  11'd100,  11'd101,  1'b1, 8'd0},
    '{1'b0, 1'b1, 11'd2000, 11'd0,    11'd1,    1'b0, 8'd1},
    '{1'b1, 1'b0, 11'd2000, 11'd1716, 11'd1728, 1'b0, 8'd0},
    '{1'b0, 1'b0, 11'd1720, 11'd0,    11'd2,    1'b0, 8'd8}
  };

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  function automatic logic [10:0] cfgWord(input logic [1:0] aType, input logic shortL,
      input logic seq8, input logic srcB, input logic blank, input logic dirB,
      input logic polB, input logic dirA, input logic polA);
    return {1'b0, aType, shortL, seq8, srcB, blank, dirB, polB, dirA, polA};
  endfunction

  task automatic writeReg(input logic [2:0] a, input logic [10:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic pinVal(input int sel);
    return (sel == 0) ? pinAOut : pinBOut;
  endfunction

  task automatic measure(input int sel, output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    @(negedge clk);
    while (pinVal(sel) != 1'b0 && guard < 40000) begin @(negedge clk); guard++; end
    while (pinVal(sel) != 1'b1 && guard < 40000) begin @(negedge clk); guard++; end
    while (pinVal(sel) == 1'b1 && guard < 40000) begin hi++; @(negedge clk); guard++; end
    while (pinVal(sel) == 1'b0 && guard < 40000) begin lo++; @(negedge clk); guard++; end
  endtask

  task automatic countRises(input int sel, input int window, output int n);
    logic prev, cur;
    n = 0;
    @(negedge clk);
    prev = pinVal(sel);
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      cur = pinVal(sel);
      if (cur && !prev) n++;
      prev = cur;
    end
  endtask

  function automatic int modelWindow(input vecT v);
    int len, ph, p;
    len = v.shortL ? 1716 : 1728;
    ph  = (int'(v.trig) > len - 1) ? len - 1 : int'(v.trig);
    p   = (ph + int'(v.delay)) % len;
    return ((p >= int'(v.hBeg) && p < int'(v.hEnd)) ? 1 : 0) ^ int'(v.polB);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo, n, cnt;
    logic ref0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "pinAOe", pinAOe, 0);
    check("R1", "pinBOe", pinBOe, 0);
    check("R1", "pinAOut", pinAOut, 0);
    check("R1", "pinBOut", pinBOut, 0);
    check("R1", "blankOut", blankOut, 1);

    // table: resync from pin A, observe pin B window (R3 R4 R5 R6)
    for (int k = 0; k < 6; k++) begin
      vecT v;
      v = VECS[k];
      writeReg(3'd0, cfgWord(2'b00, v.shortL, 1'b0, 1'b0, 1'b0, 1'b1, v.polB, 1'b0, v.polA));
      writeReg(3'd1, v.trig);
      writeReg(3'd2, v.hBeg);
      writeReg(3'd3, v.hEnd);
      @(negedge clk) pinAIn = v.polA;
      @(negedge clk);
      @(negedge clk) pinAIn = ~v.polA;
      @(posedge clk);
      repeat (int'(v.delay)) @(posedge clk);
      @(negedge clk);
      check("R4", $sformatf("vector %0d pinBOut", k), pinBOut, modelWindow(v));
      pinAIn = v.polA;
    end

    // R2 direction
    writeReg(3'd0, cfgWord(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    @(negedge clk);
    check("R2", "pinBOe input", pinBOe, 0);
    check("R2", "pinBOut input", pinBOut, 0);
    check("R2", "pinAOe output", pinAOe, 1);

    // R8 vertical pulse, 3 lines per field
    writeReg(3'd6, 11'd3);
    measure(0, hi, lo);
    check("R8", "vsync high", hi, 1716);
    check("R8", "vsync low", lo, 3432);
    // R3 pin A active low
    writeReg(3'd0, cfgWord(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    measure(0, hi, lo);
    check("R3", "inverted high", hi, 3432);
    check("R3", "inverted low", lo, 1716);

    // R9 frame level, 2 lines per field
    writeReg(3'd6, 11'd2);
    writeReg(3'd0, cfgWord(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    measure(0, hi, lo);
    check("R9", "frame high", hi, 3432);
    check("R9", "frame low", lo, 3432);

    // R10 field sequence, 1 line per field
    writeReg(3'd6, 11'd1);
    writeReg(3'd0, cfgWord(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    measure(0, hi, lo);
    check("R10", "seq4 high", hi, 1716);
    check("R10", "seq4 low", lo, 5148);
    writeReg(3'd0, cfgWord(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    measure(0, hi, lo);
    check("R10", "seq8 low", lo, 12012);

    // R11 unused code stays inactive
    writeReg(3'd0, cfgWord(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    n = 0;
    for (int i = 0; i < 2000; i++) begin @(negedge clk); if (pinAOut) n++; end
    check("R11", "active samples pol0", n, 0);
    writeReg(3'd0, cfgWord(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    n = 0;
    for (int i = 0; i < 2000; i++) begin @(negedge clk); if (!pinAOut) n++; end
    check("R11", "active samples pol1", n, 0);

    // R6 R7 pin B window with and without blanking suppression
    writeReg(3'd6, 11'd3);
    writeReg(3'd2, 11'd10);
    writeReg(3'd3, 11'd20);
    writeReg(3'd4, 11'd1);
    writeReg(3'd5, 11'd1);
    writeReg(3'd0, cfgWord(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    measure(1, hi, lo);
    check("R6", "window width", hi, 10);
    countRises(1, 5148, n);
    check("R6", "pulses per field", n, 3);
    writeReg(3'd0, cfgWord(2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
    countRises(1, 5148, n);
    check("R7", "pulses per field", n, 1);

    // R12 resync from pin B, seen on pin A line-rate transitions
    writeReg(3'd6, 11'd2);
    writeReg(3'd1, 11'd1000);
    writeReg(3'd0, cfgWord(2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    pinBIn = 1'b0;
    @(negedge clk);
    @(negedge clk) pinBIn = 1'b1;
    @(posedge clk);
    @(negedge clk) ref0 = pinAOut;
    cnt = 0;
    while (cnt < 4000) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (pinAOut != ref0) break;
    end
    check("R12", "clocks to next line", cnt, 716);

    // R13 blanking from pin B input
    writeReg(3'd0, cfgWord(2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    @(negedge clk) pinBIn = 1'b1;
    @(negedge clk);
    check("R13", "blank pin high pol0", blankOut, 0);
    pinBIn = 1'b0;
    @(negedge clk);
    check("R13", "blank pin low pol0", blankOut, 1);
    writeReg(3'd0, cfgWord(2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
    @(negedge clk);
    check("R13", "blank pin low pol1", blankOut, 0);
    writeReg(3'd6, 11'd1);
    writeReg(3'd4, 11'd0);
    writeReg(3'd5, 11'd0);
    writeReg(3'd0, cfgWord(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    repeat (1720) @(negedge clk);
    check("R13", "line range inside", blankOut, 0);
    writeReg(3'd4, 11'd1);
    @(negedge clk);
    check("R13", "line range outside", blankOut, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule